// File: doc/BRIEF.md
# Multi-Lane Packet Framing Striper

This block frames transaction-layer and link-layer packets for a byte-per-lane link of 1, 2, 4, 8 or 16 lanes. Each packet arrives as a byte stream on its own ready/valid input. The block wraps each packet in a start control symbol and an END control symbol. It then spreads the result over the lanes, one symbol per lane per symbol time. Encoding, scrambling, clock-compensation insertion and CRC generation belong to neighbouring blocks.

The core clock runs at the lane slot rate, so one symbol time spans `LANES` clocks. Each clock decides the symbol for one lane, working in lane order. When the last lane of a symbol time has been decided, the whole symbol time appears on the output registers, and `symValid` marks it for one clock.

Packet starts are placed only on lanes whose number is a multiple of four. On links of four lanes or fewer, this means lane 0 only. Lanes left over after an END carry a PAD control symbol when more traffic is waiting, and idle data otherwise. A pending link-layer packet wins over a pending transaction packet. Because of this, both kinds of start can land in one symbol time.

Top module: `lane_framer`

## Requirements
- R1: While reset is held, laneSym, laneK and symValid are zero, and tlpReady and dllpReady are low.
- R2: symValid pulses once every LANES clocks. Lane i of a symbol time is laneSym[8i+7:8i] with control flag laneK[i].
- R3: A transaction packet is emitted as start symbol FBh (K=1), then its bytes as data (K=0), then END FDh (K=1) in the slot right after the last byte.
- R4: A link-layer packet is emitted as start symbol 5Ch (K=1), then its bytes as data, then END FDh (K=1).
- R5: A start symbol occupies only a lane whose number is a multiple of four. A packet that becomes pending elsewhere waits for the next such lane.
- R6: With no packet pending, every lane carries 00h with K=0.
- R7: A lane after END and before the next legal start lane carries PAD F7h (K=1) if a packet is pending, and 00h (K=0) otherwise.
- R8: When both inputs are pending at a legal start lane, the link-layer packet starts first.
- R9: A link-layer packet that ends before lane 4 of an x8 symbol time is followed by a transaction start on lane 4 of the same symbol time.
- R10: Packet bytes fill lanes in increasing order and continue at lane 0 of the next symbol time. One byte is taken per ready/valid handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane slot clock |
| rstN | input | 1 | Synchronous reset, active low |
| tlpValid | input | 1 | Transaction byte available |
| tlpData | input | 8 | Transaction byte |
| tlpLast | input | 1 | Final byte of the transaction packet |
| tlpReady | output | 1 | Transaction byte taken this clock |
| dllpValid | input | 1 | Link-layer byte available |
| dllpData | input | 8 | Link-layer byte |
| dllpLast | input | 1 | Final byte of the link-layer packet |
| dllpReady | output | 1 | Link-layer byte taken this clock |
| laneSym | output | 8*LANES | Symbol per lane, lane i at bits 8i+7:8i |
| laneK | output | LANES | Control flag per lane |
| symValid | output | 1 | New symbol time on laneSym/laneK |

## Verification
The hardest case to reach from the ports is a link-layer start and a transaction start sharing one symbol time. It needs both sources pending at exactly lane 0, with a link-layer packet short enough to end before lane 4. The stimulus waits for a symValid pulse, which marks the clock where lane 0 is being decided. It then raises both valids at once, so the arbitration and the refill onto lane 4 happen deterministically. The same alignment is used to steer a packet end onto lane 4, which forces three PAD lanes before a queued packet may start again.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic [2:0] {
    SK_IDLE, SK_STP, SK_SDP, SK_END, SK_PAD, SK_TDAT, SK_DDAT
  } symKind_t;

  localparam logic [7:0] CODE_STP  = 8'hFB;
  localparam logic [7:0] CODE_SDP  = 8'h5C;
  localparam logic [7:0] CODE_END  = 8'hFD;
  localparam logic [7:0] CODE_PAD  = 8'hF7;
  localparam logic [7:0] CODE_IDLE = 8'h00;

  typedef struct packed {
    symKind_t kind;
    logic     slotEnd;
  } slotStrb_t;
endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tlpValid,
  input  logic          tlpLast,
  input  logic          dllpValid,
  input  logic          dllpLast,
  output logic          tlpReady,
  output logic          dllpReady,
  output slotStrb_t     strb,
  output logic [LW-1:0] laneIdx
);
  typedef enum logic [1:0] {FS_IDLE, FS_TBODY, FS_DBODY, FS_END} fState_t;

  fState_t  state, stateNxt;
  symKind_t kindC;
  logic     startOk, lastLane;

  assign lastLane = (laneIdx == LW'(LANES - 1));

  generate
    if (LANES > 2) begin : g_wide
      assign startOk = (laneIdx[1:0] == 2'b00);
    end else begin : g_narrow
      assign startOk = (laneIdx == '0);
    end
  endgenerate

  always_comb begin
    kindC     = SK_IDLE;
    stateNxt  = state;
    tlpReady  = 1'b0;
    dllpReady = 1'b0;
    case (state)
      FS_IDLE: begin
        if (startOk) begin
          if (dllpValid) begin
            kindC = SK_SDP; stateNxt = FS_DBODY;
          end else if (tlpValid) begin
            kindC = SK_STP; stateNxt = FS_TBODY;
          end
        end else if (tlpValid || dllpValid) begin
          kindC = SK_PAD;
        end
      end
      FS_TBODY: begin
        if (tlpValid) begin
          kindC = SK_TDAT; tlpReady = 1'b1;
          if (tlpLast) stateNxt = FS_END;
        end else begin
          kindC = SK_PAD;
        end
      end
      FS_DBODY: begin
        if (dllpValid) begin
          kindC = SK_DDAT; dllpReady = 1'b1;
          if (dllpLast) stateNxt = FS_END;
        end else begin
          kindC = SK_PAD;
        end
      end
      FS_END: begin
        kindC = SK_END; stateNxt = FS_IDLE;
      end
      default: stateNxt = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= FS_IDLE;
      laneIdx <= '0;
    end else begin
      state   <= stateNxt;
      laneIdx <= lastLane ? '0 : laneIdx + 1'b1;
    end
  end

  assign strb.kind    = kindC;
  assign strb.slotEnd = lastLane;

  // R5: starts only on legal lanes
  a_r5_start_lane: assert property (@(posedge clk) disable iff (!rstN)
    (strb.kind == SK_STP || strb.kind == SK_SDP) |-> startOk);
  // R10: at most one source handshakes per slot
  a_r10_one_ready: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tlpReady, dllpReady}));
  // R3: END follows the final transaction byte
  a_r3_end_follows: assert property (@(posedge clk) disable iff (!rstN)
    (tlpValid && tlpReady && tlpLast) |=> (strb.kind == SK_END));
  // R8: a transaction start never overtakes a waiting link-layer packet
  a_r8_dllp_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.kind == SK_STP) |-> !dllpValid);
endmodule

// File: rtl/framer_dp.sv
module framer_dp
  import framer_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  slotStrb_t          strb,
  input  logic [LW-1:0]      laneIdx,
  input  logic [7:0]         tlpData,
  input  logic [7:0]         dllpData,
  output logic [LANES*8-1:0] laneSym,
  output logic [LANES-1:0]   laneK,
  output logic               symValid
);
  logic [7:0]         curSym;
  logic               curK;
  logic [LANES*8-1:0] stgSym;
  logic [LANES-1:0]   stgK;

  always_comb begin
    curSym = CODE_IDLE;
    curK   = 1'b0;
    case (strb.kind)
      SK_STP:  begin curSym = CODE_STP; curK = 1'b1; end
      SK_SDP:  begin curSym = CODE_SDP; curK = 1'b1; end
      SK_END:  begin curSym = CODE_END; curK = 1'b1; end
      SK_PAD:  begin curSym = CODE_PAD; curK = 1'b1; end
      SK_TDAT: curSym = tlpData;
      SK_DDAT: curSym = dllpData;
      default: curSym = CODE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgSym   <= '0;
      stgK     <= '0;
      laneSym  <= '0;
      laneK    <= '0;
      symValid <= 1'b0;
    end else begin
      stgSym[int'(laneIdx)*8 +: 8] <= curSym;
      stgK[laneIdx]                <= curK;
      symValid                     <= strb.slotEnd;
      if (strb.slotEnd) begin
        for (int i = 0; i < LANES; i++) begin
          laneSym[i*8 +: 8] <= (i == LANES - 1) ? curSym : stgSym[i*8 +: 8];
          laneK[i]          <= (i == LANES - 1) ? curK   : stgK[i];
        end
      end
    end
  end

  // R2: a new symbol time appears just as the slot counter restarts at lane 0
  a_r2_frame_boundary: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> (laneIdx == '0));
  // R2: outputs stay frozen between symbol-time boundaries
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!symValid && $past(rstN) && !$past(strb.slotEnd)) |-> $stable(laneSym));
endmodule

// File: rtl/lane_framer.sv
module lane_framer
  import framer_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tlpValid,
  input  logic [7:0]         tlpData,
  input  logic               tlpLast,
  output logic               tlpReady,
  input  logic               dllpValid,
  input  logic [7:0]         dllpData,
  input  logic               dllpLast,
  output logic               dllpReady,
  output logic [LANES*8-1:0] laneSym,
  output logic [LANES-1:0]   laneK,
  output logic               symValid
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  slotStrb_t     strb;
  logic [LW-1:0] laneIdx;

  framer_ctrl #(.LANES(LANES), .LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .tlpValid(tlpValid), .tlpLast(tlpLast),
    .dllpValid(dllpValid), .dllpLast(dllpLast),
    .tlpReady(tlpReady), .dllpReady(dllpReady),
    .strb(strb), .laneIdx(laneIdx)
  );

  framer_dp #(.LANES(LANES), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .laneIdx(laneIdx),
    .tlpData(tlpData), .dllpData(dllpData),
    .laneSym(laneSym), .laneK(laneK), .symValid(symValid)
  );
endmodule

// File: tb/sim_lane_framer.sv
module sim_lane_framer;
  localparam int LANES  = 8;
  localparam int CLK_NS = 10;

  logic clk, rstN;
  logic tlpValid, tlpLast, dllpValid, dllpLast;
  logic [7:0] tlpData, dllpData;
  logic tlpReady, dllpReady, symValid;
  logic [LANES*8-1:0] laneSym;
  logic [LANES-1:0]   laneK;

  int checks = 0;
  int errors = 0;
  logic [8:0] cap [0:4095];
  int capN = 0;

  lane_framer #(.LANES(LANES)) u0 (
    .clk(clk), .rstN(rstN),
    .tlpValid(tlpValid), .tlpData(tlpData), .tlpLast(tlpLast), .tlpReady(tlpReady),
    .dllpValid(dllpValid), .dllpData(dllpData), .dllpLast(dllpLast), .dllpReady(dllpReady),
    .laneSym(laneSym), .laneK(laneK), .symValid(symValid)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (symValid && capN <= 4096 - LANES)
        for (int i = 0; i < LANES; i++) begin
          cap[capN] = {laneK[i], laneSym[i*8 +: 8]};
          capN++;
        end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int firstK();
    for (int i = 0; i < capN; i++) if (cap[i][8]) return i;
    return -1;
  endfunction

  task automatic align();
    capN = 0;
    @(negedge clk iff symValid);
  endtask

  task automatic settle();
    repeat (4*LANES) @(negedge clk);
  endtask

  // drives one or two back-to-back packets; called at a negedge
  task automatic send(bit isD, int n1, int n2, logic [7:0] base);
    int idx = 0;
    int total = n1 + n2;
    bit took;
    while (idx < total) begin
      if (isD) begin
        dllpValid = 1'b1; dllpData = base + 8'(idx);
        dllpLast = (idx == n1 - 1) || (idx == total - 1);
      end else begin
        tlpValid = 1'b1; tlpData = base + 8'(idx);
        tlpLast = (idx == n1 - 1) || (idx == total - 1);
      end
      #1;
      took = isD ? dllpReady : tlpReady;
      @(posedge clk);
      if (took) idx++;
      @(negedge clk);
    end
    if (isD) begin dllpValid = 1'b0; dllpLast = 1'b0; end
    else begin tlpValid = 1'b0; tlpLast = 1'b0; end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "laneSym", int'(laneSym != '0), 0);
    chk("R1", "laneK", int'(laneK), 0);
    chk("R1", "symValid", int'(symValid), 0);
    chk("R1", "ready", int'({tlpReady, dllpReady}), 0);
    rstN = 1'b1;
  endtask

  task automatic t_idle();
    int pulses = 0;
    int last = -1;
    int gapBad = 0;
    align();
    for (int c = 0; c < 10*LANES; c++) begin
      @(negedge clk);
      if (symValid) begin
        if (last >= 0 && c - last != LANES) gapBad++;
        last = c;
        pulses++;
      end
    end
    chk("R2", "pulse count", pulses, 10);
    chk("R2", "pulse spacing errors", gapBad, 0);
    for (int i = 0; i < capN; i++) chk("R6", "idle lane", int'(cap[i]), 9'h000);
  endtask

  task automatic t_tlp();
    int s;
    align();
    send(0, 5, 0, 8'hA0);
    settle();
    s = firstK();
    chk("R5", "start lane mod 4", s % 4, 0);
    for (int i = 0; i < s; i++) chk("R6", "pre-packet lane", int'(cap[i]), 9'h000);
    chk("R3", "STP", int'(cap[s]), 9'h1FB);
    for (int i = 0; i < 5; i++) chk("R3", "tlp byte", int'(cap[s+1+i]), 9'h0A0 + i);
    chk("R3", "END", int'(cap[s+6]), 9'h1FD);
    chk("R7", "fill without pending", int'(cap[s+7]), 9'h000);
  endtask

  task automatic t_dllp();
    int s;
    align();
    send(1, 2, 0, 8'hC0);
    settle();
    s = firstK();
    chk("R4", "SDP", int'(cap[s]), 9'h15C);
    chk("R4", "dllp byte0", int'(cap[s+1]), 9'h0C0);
    chk("R4", "dllp byte1", int'(cap[s+2]), 9'h0C1);
    chk("R4", "END", int'(cap[s+3]), 9'h1FD);
    chk("R6", "after packet", int'(cap[s+4]), 9'h000);
  endtask

  task automatic t_both();
    int s;
    align();
    fork
      send(1, 2, 0, 8'hD0);
      send(0, 3, 0, 8'hB0);
    join
    settle();
    s = firstK();
    chk("R8", "link-layer first", int'(cap[s]), 9'h15C);
    chk("R4", "END of dllp", int'(cap[s+3]), 9'h1FD);
    chk("R9", "STP on lane 4", int'(cap[s+4]), 9'h1FB);
    chk("R9", "same symbol time", (s+4) / LANES, s / LANES);
    chk("R9", "STP lane index", (s+4) % LANES, 4);
    chk("R3", "tlp byte2", int'(cap[s+7]), 9'h0B2);
    chk("R3", "END of tlp", int'(cap[s+8]), 9'h1FD);
  endtask

  task automatic t_pad();
    int s;
    align();
    send(0, 3, 1, 8'hE0);
    settle();
    s = firstK();
    chk("R3", "END on lane 4", int'(cap[s+4]), 9'h1FD);
    for (int i = 5; i < 8; i++) chk("R7", "PAD while pending", int'(cap[s+i]), 9'h1F7);
    chk("R5", "second STP waits for lane 0", int'(cap[s+8]), 9'h1FB);
    chk("R5", "second STP lane", (s+8) % 4, 0);
    chk("R3", "second byte", int'(cap[s+9]), 9'h0E3);
    chk("R3", "second END", int'(cap[s+10]), 9'h1FD);
    chk("R7", "idle after last", int'(cap[s+11]), 9'h000);
  endtask

  task automatic t_long();
    int s;
    align();
    send(1, 12, 0, 8'h10);
    settle();
    s = firstK();
    chk("R4", "SDP", int'(cap[s]), 9'h15C);
    for (int i = 0; i < 12; i++) chk("R10", "byte order across wrap", int'(cap[s+1+i]), 9'h010 + i);
    chk("R10", "byte 7 on lane 0", (s+8) % LANES, 0);
    chk("R4", "END", int'(cap[s+13]), 9'h1FD);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tlpValid = 1'b0; tlpLast = 1'b0; tlpData = '0;
    dllpValid = 1'b0; dllpLast = 1'b0; dllpData = '0;
    rstN = 1'b0;
    t_reset();
    t_idle();
    t_tlp();
    t_dllp();
    t_both();
    t_pad();
    t_long();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule